// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block sits between a system bus host and the embedded CPU of a keyboard controller. It holds three byte registers. The host fills an input data register and the CPU drains it. The CPU fills an output data register and the host drains it. A status register is shared by both sides. Two handshake flags show whether each data register holds a byte that the far side has not yet read. A command/data flag records the kind of byte the host last sent. The CPU gets an interrupt while the input register is full and the interrupt is enabled.

The host uses a single address select bit. On a read it chooses between the output data byte and the status byte. On a write it records whether the byte is a command or plain data. Both writes land in the input data register. The CPU has separate strobes for each register. It may write only the user-defined status bits. All outputs are registered and the reset is synchronous and active-high.

Top module: `kbc_host_mailbox`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the status byte, the interrupt, the host read data and the CPU read data are all zero.
- R2: A host write stores `host_wdata` in the input data register and sets the input-full flag (status bit 1) on the next cycle.
- R3: Every host write loads the command/data flag (status bit 3) from `host_cmd_sel`, where 1 means command and 0 means data. The host cannot write the status register.
- R4: A CPU input read places the input data register on `cpu_ibuf_rdata` on the next cycle and clears the input-full flag. If a host write happens in the same cycle, the flag stays set.
- R5: A CPU output write stores `cpu_obuf_wdata` and sets the output-full flag (status bit 0) on the next cycle.
- R6: A host read with `host_cmd_sel`=0 returns the output data register on `host_rdata` on the next cycle and clears the output-full flag. If a CPU output write happens in the same cycle, the flag stays set and the read returns the old byte.
- R7: A host read with `host_cmd_sel`=1 returns the status byte as it stood before that clock edge. `host_rdata` holds its value between reads.
- R8: A CPU status write updates only the user bits 2, 4, 5, 6 and 7. Bits 0, 1 and 3 keep their hardware values, and the user bits change only on a CPU status write.
- R9: `cpu_irq` is high exactly when the input-full flag is set and `cpu_irq_en` was high at the previous edge. A CPU input read that clears the flag also drops the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_cmd_sel | input | 1 | Host address select: 0 data, 1 command/status |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| cpu_obuf_wr | input | 1 | CPU write strobe for the output data register |
| cpu_obuf_wdata | input | DATA_W | CPU output data |
| cpu_ibuf_rd | input | 1 | CPU read strobe for the input data register |
| cpu_ibuf_rdata | output | DATA_W | Registered CPU read data |
| cpu_stat_wr | input | 1 | CPU status write strobe |
| cpu_stat_wdata | input | DATA_W | CPU status write data |
| cpu_stat_rdata | output | DATA_W | Live status byte for the CPU |
| cpu_irq_en | input | 1 | Input-full interrupt enable |
| cpu_irq | output | 1 | Input-full interrupt to the CPU |

## Verification
The bench targets same-cycle collisions. One is a host data read against a CPU output write: a design where the clear wins would lose the new byte's flag. Another is a host write against a CPU input read: a design that drops the flag would leave a byte unannounced. A CPU status write of all ones must leave the hardware flags alone, and a design that masks it wrongly would corrupt OBF, IBF or the command flag. A status read must return the pre-edge byte, and a design with a one-cycle skew would show it. Gating the interrupt with the enable catches an interrupt that ignores its enable or outlives the flag.

// File: rtl/kbc_mbx_pkg.sv
package kbc_mbx_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;
endpackage

// File: rtl/kbc_mbx_datareg.sv
module kbc_mbx_datareg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= din;
  end
endmodule

// File: rtl/kbc_mbx_status.sv
module kbc_mbx_status
  import kbc_mbx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_wr,
  input  logic         host_cmd_sel,
  input  logic         host_data_rd,
  input  logic         cpu_obuf_wr,
  input  logic         cpu_ibuf_rd,
  input  logic         cpu_stat_wr,
  input  logic [W-1:0] cpu_stat_wdata,
  input  logic         irq_en,
  output logic [W-1:0] status,
  output logic         irq
);
  localparam logic [W-1:0] HW_MASK =
    (W'(1) << OBF_BIT) | (W'(1) << IBF_BIT) | (W'(1) << CD_BIT);
  localparam logic [W-1:0] USER_MASK = ~HW_MASK;

  logic         obf_q, ibf_q, cd_q;
  logic         obf_d, ibf_d;
  logic [W-1:0] user_q;

  // set beats clear on the same cycle
  always_comb begin
    obf_d = cpu_obuf_wr ? 1'b1 : (host_data_rd ? 1'b0 : obf_q);
    ibf_d = host_wr     ? 1'b1 : (cpu_ibuf_rd  ? 1'b0 : ibf_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obf_q  <= 1'b0;
      ibf_q  <= 1'b0;
      cd_q   <= 1'b0;
      user_q <= '0;
      irq    <= 1'b0;
    end else begin
      obf_q <= obf_d;
      ibf_q <= ibf_d;
      irq   <= ibf_d & irq_en;
      if (host_wr)     cd_q   <= host_cmd_sel;
      if (cpu_stat_wr) user_q <= cpu_stat_wdata & USER_MASK;
    end
  end

  always_comb begin
    status          = user_q;
    status[OBF_BIT] = obf_q;
    status[IBF_BIT] = ibf_q;
    status[CD_BIT]  = cd_q;
  end

  assert_ibf_set_R2: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> status[IBF_BIT]);
  assert_cd_load_R3: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> status[CD_BIT] == $past(host_cmd_sel));
  assert_ibf_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_ibuf_rd && !host_wr) |=> !status[IBF_BIT]);
  assert_obf_set_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_obuf_wr |=> status[OBF_BIT]);
  assert_obf_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (host_data_rd && !cpu_obuf_wr) |=> !status[OBF_BIT]);
  assert_hw_bits_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_stat_wr && !host_wr && !host_data_rd && !cpu_obuf_wr && !cpu_ibuf_rd)
      |=> (status & HW_MASK) == $past(status & HW_MASK));
  assert_user_bits_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cpu_stat_wr |=> (status & USER_MASK) == $past(status & USER_MASK));
  assert_irq_needs_ibf_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> status[IBF_BIT]);
endmodule

// File: rtl/kbc_mbx_rdport.sv
module kbc_mbx_rdport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (rd) dout <= din;
  end
endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_cmd_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cpu_obuf_wr,
  input  logic [DATA_W-1:0] cpu_obuf_wdata,
  input  logic              cpu_ibuf_rd,
  output logic [DATA_W-1:0] cpu_ibuf_rdata,
  input  logic              cpu_stat_wr,
  input  logic [DATA_W-1:0] cpu_stat_wdata,
  output logic [DATA_W-1:0] cpu_stat_rdata,
  input  logic              cpu_irq_en,
  output logic              cpu_irq
);
  logic [DATA_W-1:0] ibuf_q, obuf_q, status;
  logic [DATA_W-1:0] host_mux;
  logic              host_data_rd;

  assign host_data_rd = host_rd & ~host_cmd_sel;
  assign host_mux     = host_cmd_sel ? status : obuf_q;

  kbc_mbx_datareg #(.W(DATA_W)) u_ibuf (
    .clk(clk), .rst(rst), .ld(host_wr), .din(host_wdata), .q(ibuf_q));

  kbc_mbx_datareg #(.W(DATA_W)) u_obuf (
    .clk(clk), .rst(rst), .ld(cpu_obuf_wr), .din(cpu_obuf_wdata), .q(obuf_q));

  kbc_mbx_status #(.W(DATA_W)) u_status (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_cmd_sel(host_cmd_sel), .host_data_rd(host_data_rd),
    .cpu_obuf_wr(cpu_obuf_wr), .cpu_ibuf_rd(cpu_ibuf_rd),
    .cpu_stat_wr(cpu_stat_wr), .cpu_stat_wdata(cpu_stat_wdata),
    .irq_en(cpu_irq_en), .status(status), .irq(cpu_irq));

  kbc_mbx_rdport #(.W(DATA_W)) u_host_rd (
    .clk(clk), .rst(rst), .rd(host_rd), .din(host_mux), .dout(host_rdata));

  kbc_mbx_rdport #(.W(DATA_W)) u_cpu_rd (
    .clk(clk), .rst(rst), .rd(cpu_ibuf_rd), .din(ibuf_q), .dout(cpu_ibuf_rdata));

  assign cpu_stat_rdata = status;

  assert_cpu_read_data_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_ibuf_rd |=> cpu_ibuf_rdata == $past(ibuf_q));
  assert_host_data_read_R6: assert property (@(posedge clk) disable iff (rst)
    host_data_rd |=> host_rdata == $past(obuf_q));
  assert_host_status_read_R7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_cmd_sel) |=> host_rdata == $past(status));
  assert_host_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/kbc_host_mailbox_test.sv
module kbc_host_mailbox_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       host_wr, host_rd, host_cmd_sel;
  logic [7:0] host_wdata, host_rdata;
  logic       cpu_obuf_wr, cpu_ibuf_rd, cpu_stat_wr, cpu_irq_en, cpu_irq;
  logic [7:0] cpu_obuf_wdata, cpu_ibuf_rdata, cpu_stat_wdata, cpu_stat_rdata;

  always #10 clk = ~clk;

  kbc_host_mailbox #(.DATA_W(8)) uut (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_cmd_sel(host_cmd_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpu_obuf_wr(cpu_obuf_wr), .cpu_obuf_wdata(cpu_obuf_wdata),
    .cpu_ibuf_rd(cpu_ibuf_rd), .cpu_ibuf_rdata(cpu_ibuf_rdata),
    .cpu_stat_wr(cpu_stat_wr), .cpu_stat_wdata(cpu_stat_wdata),
    .cpu_stat_rdata(cpu_stat_rdata), .cpu_irq_en(cpu_irq_en), .cpu_irq(cpu_irq));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [7:0] m_ibuf, m_obuf, m_hrd, m_crd, m_user;
  logic       m_obf, m_ibf, m_cd, m_irq;

  function automatic logic [7:0] m_stat();
    return m_user | {4'b0000, m_cd, 1'b0, m_ibf, m_obf};
  endfunction

  task automatic model_step();
    logic [7:0] old_stat;
    if (rst) begin
      m_ibuf = 0; m_obuf = 0; m_hrd = 0; m_crd = 0; m_user = 0;
      m_obf = 0; m_ibf = 0; m_cd = 0; m_irq = 0;
    end else begin
      old_stat = m_stat();
      if (host_rd)     m_hrd = host_cmd_sel ? old_stat : m_obuf;
      if (cpu_ibuf_rd) m_crd = m_ibuf;
      if (cpu_obuf_wr)                   m_obf = 1;
      else if (host_rd && !host_cmd_sel) m_obf = 0;
      if (host_wr)          m_ibf = 1;
      else if (cpu_ibuf_rd) m_ibf = 0;
      if (host_wr) begin m_cd = host_cmd_sel; m_ibuf = host_wdata; end
      if (cpu_obuf_wr) m_obuf = cpu_obuf_wdata;
      if (cpu_stat_wr) m_user = cpu_stat_wdata & 8'hF4;
      m_irq = m_ibf & cpu_irq_en;
    end
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5_R6 obf bit",    {7'd0, cpu_stat_rdata[0]}, {7'd0, m_obf});
    chk("R2_R4 ibf bit",    {7'd0, cpu_stat_rdata[1]}, {7'd0, m_ibf});
    chk("R3 cmd/data bit",  {7'd0, cpu_stat_rdata[3]}, {7'd0, m_cd});
    chk("R8 user bits",     cpu_stat_rdata & 8'hF4, m_user);
    chk("R6_R7 host_rdata", host_rdata, m_hrd);
    chk("R4 cpu_ibuf_rdata", cpu_ibuf_rdata, m_crd);
    chk("R9 cpu_irq",       {7'd0, cpu_irq}, {7'd0, m_irq});
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; cpu_obuf_wr = 0; cpu_ibuf_rd = 0; cpu_stat_wr = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #5;
    compare_all();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1; host_cmd_sel = 0; host_wdata = 0; cpu_obuf_wdata = 0;
    cpu_stat_wdata = 0; cpu_irq_en = 1;
    repeat (3) cyc();
    rst = 0;
    cyc();
    chk("R1 reset status", cpu_stat_rdata, 8'h00);
    chk("R1 reset irq", {7'd0, cpu_irq}, 8'h00);
    chk("R1 reset host_rdata", host_rdata, 8'h00);

    host_wr = 1; host_cmd_sel = 0; host_wdata = 8'h5A; cyc();
    chk("R2 ibf after host write", cpu_stat_rdata, 8'h02);
    chk("R9 irq with enable", {7'd0, cpu_irq}, 8'h01);
    host_rd = 1; host_cmd_sel = 1; cyc();
    chk("R7 status read", host_rdata, 8'h02);
    cpu_ibuf_rd = 1; cyc();
    chk("R4 cpu reads input byte", cpu_ibuf_rdata, 8'h5A);
    chk("R9 irq dropped on read", {7'd0, cpu_irq}, 8'h00);
    host_wr = 1; host_cmd_sel = 1; host_wdata = 8'hC3; cyc();
    chk("R3 command flag set", cpu_stat_rdata, 8'h0A);
    cpu_stat_wr = 1; cpu_stat_wdata = 8'hFF; cyc();
    chk("R8 only user bits written", cpu_stat_rdata, 8'hFE);
    cpu_stat_wr = 1; cpu_stat_wdata = 8'h00; cyc();
    chk("R8 user bits cleared, flags kept", cpu_stat_rdata, 8'h0A);
    cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h99; cyc();
    chk("R5 obf set", {7'd0, cpu_stat_rdata[0]}, 8'h01);
    host_rd = 1; host_cmd_sel = 0; cyc();
    chk("R6 host data read", host_rdata, 8'h99);
    chk("R6 obf cleared", {7'd0, cpu_stat_rdata[0]}, 8'h00);
    host_rd = 1; host_cmd_sel = 0; cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h11; cyc();
    chk("R6 collision returns old byte", host_rdata, 8'h99);
    chk("R6 collision keeps obf", {7'd0, cpu_stat_rdata[0]}, 8'h01);
    host_wr = 1; host_cmd_sel = 0; host_wdata = 8'h33; cpu_ibuf_rd = 1; cyc();
    chk("R4 collision returns old byte", cpu_ibuf_rdata, 8'hC3);
    chk("R4 collision keeps ibf", {7'd0, cpu_stat_rdata[1]}, 8'h01);
    cpu_irq_en = 0; cyc();
    chk("R9 irq gated by enable", {7'd0, cpu_irq}, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      host_wr        = ($urandom_range(0, 3) == 0);
      host_rd        = ($urandom_range(0, 2) == 0);
      host_cmd_sel   = 1'($urandom_range(0, 1));
      host_wdata     = 8'($urandom);
      cpu_obuf_wr    = ($urandom_range(0, 3) == 0);
      cpu_obuf_wdata = 8'($urandom);
      cpu_ibuf_rd    = ($urandom_range(0, 2) == 0);
      cpu_stat_wr    = ($urandom_range(0, 5) == 0);
      cpu_stat_wdata = 8'($urandom);
      cpu_irq_en     = ($urandom_range(0, 7) != 0);
      if (i == 2000) rst = 1;
      if (i == 2003) rst = 0;
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule